// File: doc/BRIEF.md
# Program Counter with Return Stack

This block holds the 12-bit fetch address for a 4K-word program space and decides, every clock, where the next fetch goes. The address is kept as an 8-bit low part and a 4-bit high part. Each cycle the block can move the address forward by one, load an absolute target for a jump or a call, vector to the fixed interrupt entry, return through an eight-level stack, or do arithmetic on the low part using an accumulator operand. The stack records return addresses for calls and for interrupts.

Low-part arithmetic has its own carry rule. An addition that carries out of the low byte bumps the high part by one, and the high part wraps modulo 16. A subtraction only changes the low byte and never borrows from the high part. This is how table dispatch and short relative branches work.

The instruction decoder drives command strobes and operands. The block presents the current fetch address and a one-cycle flag when a return finds the stack empty. When several strobes arrive together, a fixed priority picks the one that takes effect.

Top module: `pc_stack_unit`

## Requirements
- R1: After reset is released, pc_o reads 0x000 and the stack is empty, so a first return raises ret_empty_o.
- R2: When advance_i is high and no other command is active, pc_o steps by one and wraps from 0xFFF to 0x000. With no command active and advance_i low, pc_o holds.
- R3: jump_i loads the full 12-bit target_i, reaching any address.
- R4: call_i loads target_i and pushes pc_o+1 (modulo 4096). A later ret_i loads that pushed value.
- R5: irq_i loads 0x008 and pushes pc_o+1 (modulo 4096).
- R6: pcl_add_i sets the low byte to (low byte + acc_i) mod 256. It adds one to the high 4 bits (mod 16) exactly when the 8-bit sum carries out.
- R7: pcl_sub_i sets the low byte to (low byte − acc_i) mod 256 and leaves the high 4 bits unchanged, even when the subtraction borrows.
- R8: The stack is last-in first-out for up to eight stored return addresses.
- R9: A push while eight entries are held discards the oldest entry. Eight returns then yield the eight newest addresses, and the next return finds the stack empty.
- R10: ret_empty_o is high for exactly the one cycle after a return taken on an empty stack, and low otherwise. pc_o is then unspecified until a jump, call or interrupt.
- R11: Among simultaneous commands the one taking effect is, from highest: irq_i, call_i, jump_i, ret_i, pcl_add_i, pcl_sub_i, advance_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_i | input | 1 | Take interrupt: vector to 0x008 and push return address |
| call_i | input | 1 | Call target_i and push return address |
| jump_i | input | 1 | Jump to target_i |
| ret_i | input | 1 | Return: load the top of stack |
| pcl_add_i | input | 1 | Add acc_i to the low byte, with carry into the high part |
| pcl_sub_i | input | 1 | Subtract acc_i from the low byte, with no borrow |
| advance_i | input | 1 | Step to the next sequential address |
| target_i | input | 12 | Absolute target for jump and call |
| acc_i | input | 8 | Accumulator operand for low-byte arithmetic |
| pc_o | output | 12 | Current fetch address |
| ret_empty_o | output | 1 | Return was taken with the stack empty (one cycle) |

## Verification
Single commands are driven on their own first. Jumps near 0xFFF with stepping separate a true 12-bit wrap from a stuck high part. Additions with and without a low-byte carry, including one from 0xFF8 that wraps to 0x008, separate the carry rule from plain byte arithmetic. A borrowing subtraction shows that no borrow reaches the high part. Nested calls of depth eight and nine separate true LIFO order and oldest-entry overwrite from a shift or saturate scheme. Pairs of simultaneous strobes and a long pseudo-random mix check the priority order against a queue-based model on every cycle.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_INC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_ADD  = 3'd3,
    OP_RET  = 3'd4,
    OP_JMP  = 3'd5,
    OP_CALL = 3'd6,
    OP_IRQ  = 3'd7
  } pc_op_e;
endpackage

// File: rtl/pcs_pcl_alu.sv
module pcs_pcl_alu #(
  parameter int PC_W = 12,
  parameter int LO_W = 8
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic [LO_W-1:0] acc_i,
  input  logic            sub_sel_i,
  output logic [PC_W-1:0] pc_o
);
  localparam int HI_W = PC_W - LO_W;

  logic [LO_W:0]   sum_w;
  logic [LO_W-1:0] diff_w;
  logic [HI_W-1:0] hi_w;

  always_comb begin
    sum_w  = {1'b0, pc_i[LO_W-1:0]} + {1'b0, acc_i};
    diff_w = pc_i[LO_W-1:0] - acc_i;
    hi_w   = pc_i[PC_W-1:LO_W];
    if (sub_sel_i) begin
      pc_o = {hi_w, diff_w};
    end else begin
      pc_o = {hi_w + HI_W'(sum_w[LO_W]), sum_w[LO_W-1:0]};
    end
  end
endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              underflow_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [PTR_W-1:0]  wp_q, wp_d, wp_dec;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              empty_w;
  logic [DATA_W-1:0] slot_rd [DEPTH];

  always_comb begin
    wp_dec  = (wp_q == '0) ? LAST : wp_q - 1'b1;
    empty_w = (cnt_q == '0);
    wp_d    = wp_q;
    cnt_d   = cnt_q;
    if (push_i) begin
      wp_d  = (wp_q == LAST) ? '0 : wp_q + 1'b1;
      cnt_d = (cnt_q == FULL) ? cnt_q : cnt_q + 1'b1;
    end else if (pop_i && !empty_w) begin
      wp_d  = wp_dec;
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    logic              wr_en;
    assign wr_en = push_i && (wp_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (wr_en) slot_q <= push_data_i;
    end
    assign slot_rd[g] = slot_q;
  end

  assign pop_data_o  = slot_rd[wp_dec];
  assign underflow_o = pop_i && !push_i && empty_w;
endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit #(
  parameter int PC_W     = 12,
  parameter int LO_W     = 8,
  parameter int DEPTH    = 8,
  parameter int IRQ_ADDR = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_i,
  input  logic            call_i,
  input  logic            jump_i,
  input  logic            ret_i,
  input  logic            pcl_add_i,
  input  logic            pcl_sub_i,
  input  logic            advance_i,
  input  logic [PC_W-1:0] target_i,
  input  logic [LO_W-1:0] acc_i,
  output logic [PC_W-1:0] pc_o,
  output logic            ret_empty_o
);
  import pcs_pkg::*;

  localparam logic [PC_W-1:0] VEC_IRQ = PC_W'(IRQ_ADDR);

  logic [1:0]      rst_sync_q;
  logic            rst_core_n;
  pc_op_e          op_w;
  logic [PC_W-1:0] pc_q, pc_d, pc_inc, alu_pc, pop_pc;
  logic            push_w, pop_w, under_w, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_comb begin
    if      (irq_i)     op_w = OP_IRQ;
    else if (call_i)    op_w = OP_CALL;
    else if (jump_i)    op_w = OP_JMP;
    else if (ret_i)     op_w = OP_RET;
    else if (pcl_add_i) op_w = OP_ADD;
    else if (pcl_sub_i) op_w = OP_SUB;
    else if (advance_i) op_w = OP_INC;
    else                op_w = OP_HOLD;
  end

  assign pc_inc = pc_q + 1'b1;
  assign push_w = (op_w == OP_CALL) || (op_w == OP_IRQ);
  assign pop_w  = (op_w == OP_RET);

  pcs_pcl_alu #(.PC_W(PC_W), .LO_W(LO_W)) u_alu (
    .pc_i      (pc_q),
    .acc_i     (acc_i),
    .sub_sel_i (op_w == OP_SUB),
    .pc_o      (alu_pc)
  );

  pcs_ret_stack #(.DATA_W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .push_i      (push_w),
    .pop_i       (pop_w),
    .push_data_i (pc_inc),
    .pop_data_o  (pop_pc),
    .underflow_o (under_w)
  );

  always_comb begin
    unique case (op_w)
      OP_IRQ:          pc_d = VEC_IRQ;
      OP_CALL, OP_JMP: pc_d = target_i;
      OP_RET:          pc_d = pop_pc;
      OP_ADD, OP_SUB:  pc_d = alu_pc;
      OP_INC:          pc_d = pc_inc;
      default:         pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pc_q  <= '0;
      err_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      err_q <= under_w;
    end
  end

  assign pc_o        = pc_q;
  assign ret_empty_o = err_q;
endmodule

module pcs_checker #(
  parameter int PC_W = 12,
  parameter int LO_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_i,
  input logic            call_i,
  input logic            jump_i,
  input logic            ret_i,
  input logic            pcl_add_i,
  input logic            pcl_sub_i,
  input logic            advance_i,
  input logic [PC_W-1:0] target_i,
  input logic [LO_W-1:0] acc_i,
  input logic [PC_W-1:0] pc_o,
  input logic            ret_empty_o
);
  // R5
  irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i |=> (pc_o == PC_W'(8)));

  // R3
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_i && !irq_i && !call_i) |=> (pc_o == $past(target_i)));

  // R6
  add_low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pcl_add_i && !irq_i && !call_i && !jump_i && !ret_i)
      |=> (pc_o[LO_W-1:0] == LO_W'($past(pc_o[LO_W-1:0]) + $past(acc_i))));

  // R7
  sub_no_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pcl_sub_i && !irq_i && !call_i && !jump_i && !ret_i && !pcl_add_i)
      |=> (pc_o[PC_W-1:LO_W] == $past(pc_o[PC_W-1:LO_W])));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_i || call_i || jump_i || ret_i || pcl_add_i || pcl_sub_i || advance_i)
      |=> $stable(pc_o));

  // R10
  empty_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_empty_o |-> $past(ret_i && !irq_i && !call_i && !jump_i));
endmodule

bind pc_stack_unit pcs_checker #(.PC_W(PC_W), .LO_W(LO_W)) u_pcs_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .irq_i       (irq_i),
  .call_i      (call_i),
  .jump_i      (jump_i),
  .ret_i       (ret_i),
  .pcl_add_i   (pcl_add_i),
  .pcl_sub_i   (pcl_sub_i),
  .advance_i   (advance_i),
  .target_i    (target_i),
  .acc_i       (acc_i),
  .pc_o        (pc_o),
  .ret_empty_o (ret_empty_o)
);

// File: tb/pc_stack_unit_tb_top.sv
module pc_stack_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_i, call_i, jump_i, ret_i, pcl_add_i, pcl_sub_i, advance_i;
  logic [11:0] target_i;
  logic [7:0]  acc_i;
  logic [11:0] pc_o;
  logic        ret_empty_o;

  int checks = 0;
  int failures = 0;
  int pcm = 0;
  bit known = 1'b1;
  int stk[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  pc_stack_unit dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .call_i(call_i), .jump_i(jump_i),
    .ret_i(ret_i), .pcl_add_i(pcl_add_i), .pcl_sub_i(pcl_sub_i),
    .advance_i(advance_i), .target_i(target_i), .acc_i(acc_i),
    .pc_o(pc_o), .ret_empty_o(ret_empty_o)
  );

  task automatic clear_inputs();
    irq_i = 0; call_i = 0; jump_i = 0; ret_i = 0;
    pcl_add_i = 0; pcl_sub_i = 0; advance_i = 0;
    target_i = '0; acc_i = '0;
  endtask

  task automatic model_push(int v);
    stk.push_back(v & 12'hFFF);
    if (stk.size() > 8) void'(stk.pop_front());
  endtask

  task automatic compare(string tag, bit exp_err);
    checks++;
    if (known && (int'(pc_o) != pcm)) begin
      failures++;
      $display("FAIL %s pc actual=%03h expected=%03h", tag, pc_o, pcm[11:0]);
    end
    checks++;
    if (ret_empty_o !== exp_err) begin
      failures++;
      $display("FAIL %s ret_empty actual=%0b expected=%0b", tag, ret_empty_o, exp_err);
    end
  endtask

  // Drive one cycle of commands (called just after a falling edge).
  task automatic step(string tag, bit irq, bit call, bit jmp, bit ret,
                      bit add, bit sub, bit adv, int tgt, int acc);
    bit e;
    int lo, hi, s;
    irq_i = irq; call_i = call; jump_i = jmp; ret_i = ret;
    pcl_add_i = add; pcl_sub_i = sub; advance_i = adv;
    target_i = tgt[11:0]; acc_i = acc[7:0];
    @(posedge clk);
    e = 0;
    lo = pcm & 255;
    hi = (pcm >> 8) & 15;
    if (irq) begin
      model_push(pcm + 1); pcm = 8; known = 1;
    end else if (call) begin
      model_push(pcm + 1); pcm = tgt & 12'hFFF; known = 1;
    end else if (jmp) begin
      pcm = tgt & 12'hFFF; known = 1;
    end else if (ret) begin
      if (stk.size() == 0) begin e = 1; known = 0; end
      else pcm = stk.pop_back();
    end else if (add) begin
      s = lo + (acc & 255);
      pcm = (((hi + (s >> 8)) & 15) << 8) | (s & 255);
    end else if (sub) begin
      pcm = (hi << 8) | ((lo - (acc & 255)) & 255);
    end else if (adv) begin
      pcm = (pcm + 1) & 12'hFFF;
    end
    @(negedge clk);
    clear_inputs();
    compare(tag, e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    clear_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    pcm = 0; known = 1; stk.delete();
    compare("R1", 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    rst_n = 0;
    clear_inputs();
    do_reset();
    // R1: empty stack after reset; R10 flag on empty return
    step("R1", 0,0,0,1,0,0,0, 0, 0);
    step("R10", 0,0,0,0,0,0,0, 0, 0);
    step("R3", 0,0,1,0,0,0,0, 12'h000, 0);
    // R2: stepping, wrap, hold
    step("R2", 0,0,0,0,0,0,1, 0, 0);
    step("R2", 0,0,0,0,0,0,1, 0, 0);
    step("R3", 0,0,1,0,0,0,0, 12'hFFE, 0);
    step("R2", 0,0,0,0,0,0,1, 0, 0);
    step("R2", 0,0,0,0,0,0,1, 0, 0);
    step("R2", 0,0,0,0,0,0,0, 0, 0);
    // R3: any address
    step("R3", 0,0,1,0,0,0,0, 12'hABC, 0);
    step("R3", 0,0,1,0,0,0,0, 12'h5F0, 0);
    // R4: call and return
    step("R4", 0,1,0,0,0,0,0, 12'h123, 0);
    step("R4", 0,0,0,0,0,0,1, 0, 0);
    step("R4", 0,0,0,1,0,0,0, 0, 0);
    // R5: interrupt vector and return
    step("R5", 1,0,0,0,0,0,0, 0, 0);
    step("R5", 0,0,0,1,0,0,0, 0, 0);
    // R6: add with and without carry, wrap of high part
    step("R6", 0,0,1,0,0,0,0, 12'h2F0, 0);
    step("R6", 0,0,0,0,1,0,0, 0, 8'h20);
    step("R6", 0,0,0,0,1,0,0, 0, 8'h05);
    step("R6", 0,0,1,0,0,0,0, 12'hFF8, 0);
    step("R6", 0,0,0,0,1,0,0, 0, 8'h10);
    // R7: subtract with borrow keeps high part
    step("R7", 0,0,1,0,0,0,0, 12'h305, 0);
    step("R7", 0,0,0,0,0,1,0, 0, 8'h10);
    step("R7", 0,0,0,0,0,1,0, 0, 8'h01);
    // R11: priority pairs
    step("R11", 1,1,1,0,0,0,0, 12'h777, 0);
    step("R11", 0,1,1,0,0,0,0, 12'h444, 0);
    step("R11", 0,0,1,1,0,0,0, 12'h321, 0);
    step("R11", 0,0,0,1,1,0,0, 0, 8'h33);
    step("R11", 0,0,0,1,0,1,1, 0, 0);
    step("R11", 0,0,0,0,1,1,1, 0, 8'h44);
    step("R11", 0,0,0,0,0,1,1, 0, 8'h02);
    // R8: eight-deep LIFO
    do_reset();
    for (int i = 0; i < 8; i++) step("R8", 0,1,0,0,0,0,0, 12'h100 * i + 12'h010 + i, 0);
    for (int i = 0; i < 8; i++) step("R8", 0,0,0,1,0,0,0, 0, 0);
    step("R8", 0,0,0,1,0,0,0, 0, 0);
    step("R3", 0,0,1,0,0,0,0, 12'h050, 0);
    // R9: ninth push drops the oldest
    do_reset();
    for (int i = 0; i < 9; i++) step("R9", 0,1,0,0,0,0,0, 12'h0A0 + 12'h101 * i, 0);
    for (int i = 0; i < 8; i++) step("R9", 0,0,0,1,0,0,0, 0, 0);
    step("R9", 0,0,0,1,0,0,0, 0, 0);
    // R11: pseudo-random mix against the model
    do_reset();
    seed = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      step("R11", seed[31] & seed[30] & seed[29], seed[28] & seed[27],
           seed[26] & seed[25], seed[24] & seed[23], seed[22] & seed[21],
           seed[20] & seed[19], seed[18], int'(seed[15:4]), int'(seed[11:4]));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule